// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the trigger sequencer of an on-chip debug unit. Three comparator match lines, channels 0 to 2, arrive from outside. Each can be gated by its own enable bit. While the sequencer is armed it walks through three working states, S1, S2 and S3, and ends in a terminal Final state. In each working state a 4-bit code, held in a selector register for that state, decides which enabled match moves the machine and where it goes. When several enabled matches arrive in the same cycle, a move into Final wins. Among the other moves, the lowest-numbered channel wins.

Software reaches the block through a small register window of four addresses. A control register at address 0 holds the arm bit, the three channel enables and a 2-bit bank field. Address 1 is a window onto one of the three selectors, and the bank field chooses which one. The selectors can only be changed while the sequencer is disarmed. The block drives the current state, an armed flag, and a one-cycle pulse in the cycle the machine enters Final. The debug logic around it turns that pulse into a breakpoint or a trace stop.

Top module: `dbg_seq_top`

## Requirements
- R1: After synchronous reset, state_o is 0 (idle), armed_o and final_pulse_o are 0, and every register reads 0x00.
- R2: State encoding: 0 idle, 1 S1, 2 S2, 3 S3, 4 Final. The control register at address 0 has arm in bit 7, the channel enables in bits 4:2 (bit 2+n enables channel n) and the bank field in bits 1:0; bits 6:5 read 0. A control write that sets arm while disarmed moves the state to S1 on that clock edge, and matches in that cycle are ignored. A control write that clears arm returns the state to idle from any state. A control write with arm set while already armed leaves the state unchanged.
- R3: Writes to a selector while armed are ignored. Only the low 4 bits of a written selector value are kept, and bits 7:4 of a selector read as 0.
- R4: Address 1 reaches the S1, S2 and S3 selector when the bank field is 00, 01 and 10. With bank 11, address 1 reads 0 and writes to it are ignored. Addresses 2 and 3 read 0. Read data is registered: rd_data_o shows the value held at rd_addr_i in the previous cycle, before any write made in that same cycle.
- R5: A match on a channel whose enable bit is 0 has no effect on the state.
- R6: S3 codes: 0000 M0 to S1, 0001 M1 to S1, 0010 M2 to S2, 0011 M1 to Final, 0100 M0 to S2, 0101 M2 to Final, 0110 M2 to S1 and M0 to Final, 0111 M0 or M1 to Final, 1100 M0 or M1 to Final and M2 to S3, 1111 M0 or M1 to Final and M2 to S1.
- R7: S1 and S2 use the same code layout, with these targets. For S1: 0000 M0 to S2, 0001 M1 to S3, 0010 M2 to S2, 0100 M0 to S3, and the M2 target in 0110 and 1111 is S2. For S2: 0000 M0 to S1, 0001 M1 to S3, 0010 M2 to S1, 0100 M0 to S3, and the M2 target in 0110 and 1111 is S1. In both states the Final moves and the 1100 M2-to-S3 move are as in R6.
- R8: Codes 1000, 1001, 1010, 1011, 1101 and 1110 cause no transition in any state. A match that the selected code does not name has no effect.
- R9: When several enabled matches name moves in the same cycle, a move into Final is taken first. Otherwise the move of the lowest channel number is taken.
- R10: final_pulse_o is high for exactly the one cycle in which state_o first shows Final. The state then stays in Final, whatever the matches do, until arm is cleared.
- R11: While disarmed, matches have no effect and the state stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Registered read data |
| match_i | input | 3 | Comparator match lines, channel n on bit n |
| state_o | output | 3 | Current sequencer state |
| armed_o | output | 1 | Sequencer armed |
| final_pulse_o | output | 1 | One-cycle pulse on entry to Final |

## Verification
The hardest behaviour to reach from the ports is the S3 code table. S3 can only be entered by arming, programming the S1 selector to route a match there, and firing that match. The selector for S3 also has to be loaded before arming, because it is locked afterwards. The stimulus repeats this for every target state, every code and every non-empty match pattern. It narrows the enable mask through a control write after arming, and a behavioural model of the code tables predicts state, pulse and read data on every clock.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int NUM_CH   = 3;
  localparam int NUM_SEL  = 3;
  localparam int SEL_W    = 4;
  localparam int DATA_W   = 8;
  localparam int STATE_W  = 3;
  localparam int BANK_W   = 2;
  localparam int ADDR_W   = 2;

  // control register field positions
  localparam int CTRL_BANK_LSB = 0;
  localparam int CTRL_EN_LSB   = 2;
  localparam int CTRL_ARM_BIT  = 7;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_ADDR  = 2'd1;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_S1    = 3'd1,
    ST_S2    = 3'd2,
    ST_S3    = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_t;

  // selector codes with a defined meaning
  localparam logic [SEL_W-1:0] C_M0_A    = 4'b0000;
  localparam logic [SEL_W-1:0] C_M1_A    = 4'b0001;
  localparam logic [SEL_W-1:0] C_M2_A    = 4'b0010;
  localparam logic [SEL_W-1:0] C_M1_F    = 4'b0011;
  localparam logic [SEL_W-1:0] C_M0_B    = 4'b0100;
  localparam logic [SEL_W-1:0] C_M2_F    = 4'b0101;
  localparam logic [SEL_W-1:0] C_M0F_M2  = 4'b0110;
  localparam logic [SEL_W-1:0] C_M01_F   = 4'b0111;
  localparam logic [SEL_W-1:0] C_M01F_S3 = 4'b1100;
  localparam logic [SEL_W-1:0] C_M01F_M2 = 4'b1111;

  // per-state targets for the state-dependent slots of the code table
  typedef struct packed {
    seq_state_t tgt_m0_a;   // code 0000, channel 0
    seq_state_t tgt_m1_a;   // code 0001, channel 1
    seq_state_t tgt_m2_a;   // code 0010, channel 2
    seq_state_t tgt_m0_b;   // code 0100, channel 0
    seq_state_t tgt_m2_alt; // codes 0110 and 1111, channel 2
  } row_t;

  function automatic row_t row_for(input int src);
    row_t r;
    case (src)
      1:       r = '{ST_S2, ST_S3, ST_S2, ST_S3, ST_S2};
      2:       r = '{ST_S1, ST_S3, ST_S1, ST_S3, ST_S1};
      default: r = '{ST_S1, ST_S1, ST_S2, ST_S2, ST_S1};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbg_seq_regs.sv
module dbg_seq_regs
  import dbg_seq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       arm_o,
  output logic                       arm_start_o,
  output logic                       disarm_o,
  output logic [NUM_CH-1:0]          en_o,
  output logic [NUM_SEL*SEL_W-1:0]   sel_o
);

  logic              arm_q;
  logic [NUM_CH-1:0] en_q;
  logic [BANK_W-1:0] bank_q;
  logic [SEL_W-1:0]  sel_q [NUM_SEL];
  logic [DATA_W-1:0] rd_q;

  logic wr_ctrl, wr_sel, bank_ok;

  assign wr_ctrl     = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign bank_ok     = (bank_q < BANK_W'(NUM_SEL));
  assign wr_sel      = wr_en_i && (wr_addr_i == SEL_ADDR) && !arm_q && bank_ok;
  assign arm_start_o = wr_ctrl && wr_data_i[CTRL_ARM_BIT] && !arm_q;
  assign disarm_o    = wr_ctrl && !wr_data_i[CTRL_ARM_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      en_q   <= '0;
      bank_q <= '0;
    end else if (wr_ctrl) begin
      arm_q  <= wr_data_i[CTRL_ARM_BIT];
      en_q   <= wr_data_i[CTRL_EN_LSB +: NUM_CH];
      bank_q <= wr_data_i[CTRL_BANK_LSB +: BANK_W];
    end
  end

  // selector bank: tiny, kept in flops because all entries are read at once
  for (genvar b = 0; b < NUM_SEL; b++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[b] <= '0;
      end else if (wr_sel && (bank_q == BANK_W'(b))) begin
        sel_q[b] <= wr_data_i[SEL_W-1:0];
      end
    end
    assign sel_o[b*SEL_W +: SEL_W] = sel_q[b];
  end

  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] sel_view;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_ARM_BIT]              = arm_q;
    ctrl_view[CTRL_EN_LSB +: NUM_CH]     = en_q;
    ctrl_view[CTRL_BANK_LSB +: BANK_W]   = bank_q;
    sel_view = '0;
    for (int b = 0; b < NUM_SEL; b++) begin
      if (bank_q == BANK_W'(b)) sel_view[SEL_W-1:0] = sel_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr_i)
        CTRL_ADDR: rd_q <= ctrl_view;
        SEL_ADDR:  rd_q <= sel_view;
        default:   rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
  assign arm_o     = arm_q;
  assign en_o      = en_q;

  AST_SEL_LOCK: assert property (@(posedge clk) disable iff (rst)
    arm_q |=> $stable(sel_o)); // R3

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr_i) == SEL_ADDR) |-> (rd_data_o[DATA_W-1:SEL_W] == '0)); // R3

endmodule

// File: rtl/dbg_seq_decode.sv
module dbg_seq_decode
  import dbg_seq_pkg::*;
#(
  parameter int SRC = 1
)(
  input  logic [SEL_W-1:0]  code_i,
  input  logic [NUM_CH-1:0] hit_i,
  output logic              take_o,
  output seq_state_t        next_o
);

  localparam row_t ROW = row_for(SRC);

  seq_state_t tgt [NUM_CH];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) tgt[c] = ST_IDLE;
    case (code_i)
      C_M0_A:    tgt[0] = ROW.tgt_m0_a;
      C_M1_A:    tgt[1] = ROW.tgt_m1_a;
      C_M2_A:    tgt[2] = ROW.tgt_m2_a;
      C_M1_F:    tgt[1] = ST_FINAL;
      C_M0_B:    tgt[0] = ROW.tgt_m0_b;
      C_M2_F:    tgt[2] = ST_FINAL;
      C_M0F_M2: begin
        tgt[0] = ST_FINAL;
        tgt[2] = ROW.tgt_m2_alt;
      end
      C_M01_F: begin
        tgt[0] = ST_FINAL;
        tgt[1] = ST_FINAL;
      end
      C_M01F_S3: begin
        tgt[0] = ST_FINAL;
        tgt[1] = ST_FINAL;
        tgt[2] = ST_S3;
      end
      C_M01F_M2: begin
        tgt[0] = ST_FINAL;
        tgt[1] = ST_FINAL;
        tgt[2] = ROW.tgt_m2_alt;
      end
      default: ; // reserved codes: no channel has a target
    endcase
  end

  // lowest channel wins, then any move into Final overrides
  always_comb begin
    take_o = 1'b0;
    next_o = ST_IDLE;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (hit_i[c] && (tgt[c] != ST_IDLE)) begin
        take_o = 1'b1;
        next_o = tgt[c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_i[c] && (tgt[c] == ST_FINAL)) next_o = ST_FINAL;
    end
  end

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_seq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         arm_i,
  input  logic                         arm_start_i,
  input  logic                         disarm_i,
  input  logic [NUM_SEL-1:0]           take_i,
  input  logic [NUM_SEL*STATE_W-1:0]   next_i,
  output seq_state_t                   state_o,
  output logic                         final_pulse_o
);

  seq_state_t state_q, state_d;
  logic       pulse_q;
  int         idx;

  always_comb begin
    state_d = state_q;
    idx     = 0;
    if (arm_start_i) begin
      state_d = ST_S1;
    end else if (disarm_i || !arm_i) begin
      state_d = ST_IDLE;
    end else if ((state_q == ST_S1) || (state_q == ST_S2) || (state_q == ST_S3)) begin
      idx = int'(state_q) - 1;
      if (take_i[idx]) state_d = seq_state_t'(next_i[idx*STATE_W +: STATE_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_d == ST_FINAL) && (state_q != ST_FINAL);
    end
  end

  assign state_o       = state_q;
  assign final_pulse_o = pulse_q;

  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FINAL) |=> ((state_q == ST_FINAL) || (state_q == ST_IDLE))); // R10

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R10

  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_q) |-> (state_q == ST_FINAL)); // R10

  AST_NO_TAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arm_i && !arm_start_i && !disarm_i && (take_i == '0)) |=> $stable(state_q)); // R8

endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic [2:0]        match_i,
  output logic [2:0]        state_o,
  output logic              armed_o,
  output logic              final_pulse_o
);

  logic                       arm_q, arm_start, disarm;
  logic [NUM_CH-1:0]          en;
  logic [NUM_SEL*SEL_W-1:0]   sel_flat;
  logic [NUM_CH-1:0]          hit;
  logic [NUM_SEL-1:0]         take;
  logic [NUM_SEL*STATE_W-1:0] next_flat;
  seq_state_t                 state_q;

  dbg_seq_regs i_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .arm_o       (arm_q),
    .arm_start_o (arm_start),
    .disarm_o    (disarm),
    .en_o        (en),
    .sel_o       (sel_flat)
  );

  assign hit = match_i & en;

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_dec
    seq_state_t nxt;
    dbg_seq_decode #(.SRC(s + 1)) i_dec (
      .code_i (sel_flat[s*SEL_W +: SEL_W]),
      .hit_i  (hit),
      .take_o (take[s]),
      .next_o (nxt)
    );
    assign next_flat[s*STATE_W +: STATE_W] = nxt;
  end

  dbg_seq_fsm i_fsm (
    .clk           (clk),
    .rst           (rst),
    .arm_i         (arm_q),
    .arm_start_i   (arm_start),
    .disarm_i      (disarm),
    .take_i        (take),
    .next_i        (next_flat),
    .state_o       (state_q),
    .final_pulse_o (final_pulse_o)
  );

  assign state_o = state_q;
  assign armed_o = arm_q;

  AST_ARM_STATE: assert property (@(posedge clk) disable iff (rst)
    arm_q == (state_q != ST_IDLE)); // R2

  AST_START_S1: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> (state_q == ST_S1)); // R2

  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!arm_q && !wr_en_i) |=> (state_q == ST_IDLE)); // R11

  AST_MASKED_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (arm_q && !wr_en_i && (hit == '0)) |=> $stable(state_q)); // R5

endmodule

// File: tb/test_dbg_seq_top.sv
module test_dbg_seq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] match = '0;
  logic [2:0] state;
  logic       armed;
  logic       fpulse;

  always #4 clk = ~clk; // 125 MHz

  dbg_seq_top i_dbg_seq_top (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .match_i(match), .state_o(state), .armed_o(armed),
    .final_pulse_o(fpulse)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    started  = 0;
  bit    done     = 0;

  // reference model state
  int       m_state = 0;
  bit       m_pulse = 0;
  bit       m_arm   = 0;
  bit [2:0] m_en    = 0;
  bit [1:0] m_bank  = 0;
  bit [3:0] m_sel [3] = '{4'd0, 4'd0, 4'd0};
  bit [7:0] m_rd    = 0;

  // target of channel ch under code in state st (1..3), -1 when none
  function automatic int ref_tgt(int st, int code, int ch);
    case (code)
      0:  return (ch == 0) ? ((st == 1) ? 2 : 1) : -1;
      1:  return (ch == 1) ? ((st == 3) ? 1 : 3) : -1;
      2:  return (ch == 2) ? ((st == 2) ? 1 : 2) : -1;
      3:  return (ch == 1) ? 4 : -1;
      4:  return (ch == 0) ? ((st == 3) ? 2 : 3) : -1;
      5:  return (ch == 2) ? 4 : -1;
      6:  return (ch == 0) ? 4 : (ch == 2) ? ((st == 1) ? 2 : 1) : -1;
      7:  return (ch < 2) ? 4 : -1;
      12: return (ch < 2) ? 4 : 3;
      15: return (ch < 2) ? 4 : ((st == 1) ? 2 : 1);
      default: return -1;
    endcase
  endfunction

  function automatic int ref_next(int st, int code, bit [2:0] hits);
    int best = -1;
    for (int ch = 0; ch < 3; ch++)
      if (hits[ch] && ref_tgt(st, code, ch) == 4) return 4;
    for (int ch = 0; ch < 3; ch++)
      if (hits[ch] && best < 0 && ref_tgt(st, code, ch) >= 0) best = ref_tgt(st, code, ch);
    return (best < 0) ? st : best;
  endfunction

  always @(posedge clk) begin
    int       nst;
    bit [7:0] rdv;
    if (rst) begin
      m_state = 0; m_pulse = 0; m_arm = 0; m_en = 0; m_bank = 0;
      for (int b = 0; b < 3; b++) m_sel[b] = 0;
      m_rd = 0;
    end else begin
      case (rd_addr)
        2'd0: rdv = {m_arm, 2'b00, m_en, m_bank};
        2'd1: rdv = (m_bank == 2'd3) ? 8'h00 : {4'h0, m_sel[m_bank]};
        default: rdv = 8'h00;
      endcase
      nst = m_state;
      if (wr_en && wr_addr == 2'd0 && wr_data[7] && !m_arm) nst = 1;
      else if ((wr_en && wr_addr == 2'd0 && !wr_data[7]) || !m_arm) nst = 0;
      else if (m_state >= 1 && m_state <= 3)
        nst = ref_next(m_state, int'(m_sel[m_state-1]), match & m_en);
      if (wr_en && wr_addr == 2'd1 && !m_arm && m_bank != 2'd3)
        m_sel[m_bank] = wr_data[3:0];
      if (wr_en && wr_addr == 2'd0) begin
        m_arm = wr_data[7]; m_en = wr_data[4:2]; m_bank = wr_data[1:0];
      end
      m_pulse = (nst == 4) && (m_state != 4);
      m_state = nst;
      m_rd    = rdv;
    end
    started = 1;
  end

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("state", int'(state), m_state);
      chk("pulse", int'(fpulse), int'(m_pulse));
      chk("armed", int'(armed), int'(m_arm));
      chk("rd_data", int'(rd_data), int'(m_rd));
      rd_addr = rd_addr + 2'd1;
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_match(input bit [2:0] m);
    @(negedge clk); match = m;
    @(negedge clk); match = 0;
  endtask

  function automatic bit [7:0] ctrl(bit arm, bit [2:0] en, bit [1:0] bank);
    return {arm, 2'b00, en, bank};
  endfunction

  task automatic run_case(int tst, int code, bit [2:0] pat, bit [2:0] en);
    cur_req = "R2";
    wr(0, ctrl(0, 3'b111, 2'd0));
    if (tst == 2) wr(1, 8'h00);
    if (tst == 3) wr(1, 8'h01);
    wr(0, ctrl(0, 3'b111, 2'(tst - 1)));
    wr(1, 8'(code));
    wr(0, ctrl(1, 3'b111, 2'd0));
    if (tst == 2) pulse_match(3'b001);
    if (tst == 3) pulse_match(3'b010);
    wr(0, ctrl(1, en, 2'd0));
    if (en != 3'b111) cur_req = "R5";
    else if (code inside {8, 9, 10, 11, 13, 14}) cur_req = "R8";
    else if ($countones(pat) > 1) cur_req = "R9";
    else if (tst == 3) cur_req = "R6";
    else cur_req = "R7";
    pulse_match(pat);
    idle(1);
    cur_req = "R10";
    pulse_match(3'b111);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    idle(6);
    // register window and bank select
    cur_req = "R4";
    for (int b = 0; b < 4; b++) begin
      wr(0, ctrl(0, 3'b000, 2'(b)));
      wr(1, 8'hA5 + 8'(b));
      idle(4);
    end
    cur_req = "R3";
    wr(0, ctrl(1, 3'b111, 2'd1));
    wr(1, 8'h3C);
    idle(4);
    wr(0, ctrl(0, 3'b111, 2'd1));
    idle(4);
    cur_req = "R11";
    wr(0, ctrl(0, 3'b111, 2'd0));
    wr(1, 8'h07);
    pulse_match(3'b111);
    idle(2);
    cur_req = "R2";
    wr(0, ctrl(1, 3'b111, 2'd0));
    wr(0, ctrl(1, 3'b000, 2'd0));
    idle(2);
    wr(0, ctrl(0, 3'b000, 2'd0));
    // full table sweep
    for (int tst = 1; tst <= 3; tst++)
      for (int code = 0; code < 16; code++)
        for (int p = 1; p < 8; p++)
          run_case(tst, code, 3'(p), 3'b111);
    for (int code = 0; code < 16; code++)
      for (int e = 0; e < 7; e++)
        run_case(3, code, 3'b111, 3'(e));
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule